// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is a serial peripheral slave that gives a host access to a bank of 8-bit configuration registers. Every transaction is framed by an active-low chip select and carries exactly sixteen bits: a flag-plus-address byte, then a data byte. When a register is written, the value it held before the frame is returned on the serial output during the data byte. The host can therefore confirm what it replaced. A frame with the flag clear reads a register without changing it.

One reserved address does not map to a register. Each byte written to it is passed to the pixel-matrix loader as a single-cycle strobe with the byte beside it, so the whole matrix is programmed one byte per frame. Reset loads every register with its nominal default. One control bit blocks the switching of the power-pulsing bias lines, while the power-pulse signal itself keeps running.

The serial pins are taken into the system clock domain through two-flop synchronisers. The serial clock must therefore run several times slower than the system clock. The bank contents are exposed in parallel on `cfg_o`, with register i at bits [8i+7:8i].

Top module: `spi_cfg_regs`

## Requirements
- R1: A frame is sampled on rising serial-clock edges while `cs_n` is low, most significant bit first. Bit 15 is the write flag (1 = write, 0 = read), bits 14..8 are the register address, and bits 7..0 are the data.
- R2: A write frame to an address below NREG (16) stores the data byte in that register once the sixteenth rising edge has been sampled. The new value appears in `cfg_o[8*addr+7 : 8*addr]`.
- R3: `miso` is 0 during the address byte. During the data byte, `miso` shifts out, MSB first, the value the addressed register held before the frame; it changes on falling serial-clock edges.
- R4: A read frame (flag 0) changes no register and raises no matrix strobe.
- R5: If `cs_n` rises before sixteen bits have been received, no register is updated and no strobe is raised. The next frame starts again from bit 15.
- R6: A write frame to address 0x7F changes no register. It raises `mtx_valid` for exactly one system clock with `mtx_byte` equal to the data byte, and `miso` returns 0 for that frame.
- R7: Frames to addresses from NREG up to 0x7E change nothing, and `miso` returns 0 for them.
- R8: While `rst_n` is low, every register takes its default value (register 0 = 0x80, 1 = 0xAA, 2 = 0x55, 3 = 0xC8, 4 = 0x01, 5 = 0x7F, 6 = 0x40, 7 = 0x80, 8 = 0x80, 9 = 0x0A, 10 = 0x32, 11 = 0x64, 12 = 0x10, 13 = 0x20, 14 = 0x1F, 15 = 0x00). Also, `mtx_valid` is low and `miso` is 0.
- R9: `pp_bias_sw` follows `pp_pulse` while bit 0 of register NREG-1 (15) is 0, and is held at 0 while that bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low global reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| cfg_o | output | NREG*8 | Register bank contents, register i at bits [8i+7:8i] |
| mtx_valid | output | 1 | One-cycle strobe for a matrix configuration byte |
| mtx_byte | output | 8 | Matrix configuration byte |
| pp_pulse | input | 1 | Power-pulse request |
| pp_bias_sw | output | 1 | Bias-line switching control |

## Verification
A serial edge reaches the logic about three system clocks after the bench drives it, because of the synchroniser and the edge detector. A write commits and `mtx_valid` pulses about four system clocks after the sixteenth rising edge. The bench holds every serial level for six system clocks, so each `miso` bit settles long before the host-side monitor samples it at the next rising serial edge. Register contents are checked only after chip select has been high for twelve clocks. The matrix strobe is sampled on falling system-clock edges, and `pp_bias_sw` is sampled two clocks after `pp_pulse` changes.

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs #(
  parameter int NREG = 16,
  parameter logic [6:0] MTX_ADDR = 7'h7F,
  parameter logic [NREG*8-1:0] DEFAULTS = 128'h00_1F_20_10_64_32_0A_80_80_40_7F_01_C8_55_AA_80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic [NREG*8-1:0] cfg_o,
  output logic              mtx_valid,
  output logic [7:0]        mtx_byte,
  input  logic              pp_pulse,
  output logic              pp_bias_sw
);
  localparam int CW = 5;
  localparam logic [CW-1:0] NBITS = CW'(16);

  logic [2:0] sclk_q;
  logic [1:0] cs_q, mosi_q;
  logic [CW-1:0] cnt;
  logic [15:0] in_sr;
  logic [7:0] out_sr;

  wire rise    = sclk_q[1] & ~sclk_q[2];
  wire fall    = ~sclk_q[1] & sclk_q[2];
  wire cs_idle = cs_q[1];
  wire [15:0] word = {in_sr[14:0], mosi_q[1]};
  wire commit  = rise && !cs_idle && cnt == NBITS - 1'b1;
  wire wr_flag = word[15];
  wire [6:0] idx = word[14:8];

  function automatic logic [7:0] peek(input logic [6:0] a, input logic [NREG*8-1:0] r);
    peek = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (a == 7'(i)) peek = r[i*8 +: 8];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= '0;
      cs_q      <= 2'b11;
      mosi_q    <= '0;
      cnt       <= '0;
      in_sr     <= '0;
      out_sr    <= '0;
      cfg_o     <= DEFAULTS;
      mtx_valid <= 1'b0;
      mtx_byte  <= '0;
    end else begin
      sclk_q    <= {sclk_q[1:0], sclk};
      cs_q      <= {cs_q[0], cs_n};
      mosi_q    <= {mosi_q[0], mosi};
      mtx_valid <= 1'b0;
      if (cs_idle) begin
        cnt    <= '0;
        out_sr <= '0;
      end else begin
        if (rise && cnt != NBITS) begin
          in_sr <= word;
          cnt   <= cnt + 1'b1;
        end
        if (fall && cnt == CW'(8))
          out_sr <= peek(in_sr[6:0], cfg_o);
        else if (fall && cnt > CW'(8))
          out_sr <= {out_sr[6:0], 1'b0};
        if (commit && wr_flag) begin
          if (idx == MTX_ADDR) begin
            mtx_valid <= 1'b1;
            mtx_byte  <= word[7:0];
          end else begin
            for (int i = 0; i < NREG; i++)
              if (idx == 7'(i)) cfg_o[i*8 +: 8] <= word[7:0];
          end
        end
      end
    end
  end

  assign miso       = out_sr[7];
  assign pp_bias_sw = pp_pulse & ~cfg_o[(NREG-1)*8];

  AST_ADDR_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(8) |-> !miso);  // R3
  AST_IDLE_HOLDS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_idle) |-> $stable(cfg_o));  // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mtx_valid |=> !mtx_valid);  // R6
  AST_STROBE_NO_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mtx_valid |-> $stable(cfg_o));  // R6
endmodule

// File: tb/sim_spi_cfg_regs.sv
module sim_spi_cfg_regs;
  localparam int NREG = 16;
  localparam logic [NREG*8-1:0] DEF = 128'h00_1F_20_10_64_32_0A_80_80_40_7F_01_C8_55_AA_80;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, pp_pulse = 1'b0;
  logic miso, mtx_valid, pp_bias_sw;
  logic [7:0] mtx_byte;
  logic [NREG*8-1:0] cfg_o;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_miso[$];
  logic [7:0] exp_mtx[$];
  logic [7:0] model[NREG];

  always #4 clk = ~clk;

  spi_cfg_regs u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .cfg_o(cfg_o), .mtx_valid(mtx_valid), .mtx_byte(mtx_byte),
    .pp_pulse(pp_pulse), .pp_bias_sw(pp_bias_sw));

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] flat();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic load_defaults();
    for (int i = 0; i < NREG; i++) model[i] = DEF[i*8 +: 8];
  endtask

  // host-side monitor: collects the data byte and compares with the scoreboard
  int bcnt = 0;
  logic [7:0] got;
  always @(negedge cs_n) bcnt = 0;
  always @(posedge sclk) begin
    if (!cs_n) begin
      if (bcnt >= 8) got = {got[6:0], miso};
      else if (miso !== 1'b0) check("R3 address phase miso", 128'(miso), 128'h0);
      if (bcnt == 15) begin
        if (exp_miso.size() == 0) check("R3 unexpected frame", 128'(got), 128'h1ff);
        else check("R3 miso old value", 128'(got), 128'(exp_miso.pop_front()));
      end
      bcnt++;
    end
  end

  // strobe monitor
  logic prev_v = 1'b0;
  always @(negedge clk) begin
    if (rst_n && mtx_valid) begin
      if (prev_v) check("R6 strobe width", 128'h2, 128'h1);
      if (exp_mtx.size() == 0) check("R6 unexpected strobe", 128'(mtx_byte), 128'h1ff);
      else check("R6 matrix byte", 128'(mtx_byte), 128'(exp_mtx.pop_front()));
    end
    prev_v = mtx_valid;
  end

  task automatic xfer(input logic w, input logic [6:0] a, input logic [7:0] d, input int nbits);
    logic [15:0] f = {w, a, d};
    if (nbits == 16) begin
      exp_miso.push_back(a < 7'(NREG) ? model[a] : 8'h00);
      if (w) begin
        if (a == 7'h7F) exp_mtx.push_back(d);
        else if (a < 7'(NREG)) model[a] = d;
      end
    end
    @(negedge clk); cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = f[15-i];
      repeat (6) @(negedge clk);
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    load_defaults();
    repeat (5) @(negedge clk);
    check("R8 defaults in reset", 128'(cfg_o), 128'(DEF));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 defaults", 128'(cfg_o), 128'(DEF));
    check("R8 strobe low", 128'(mtx_valid), 128'h0);
    check("R8 miso low", 128'(miso), 128'h0);

    xfer(1'b0, 7'd3, 8'hFF, 16);                     // R4 read
    check("R4 read leaves bank", 128'(cfg_o), 128'(flat()));
    xfer(1'b1, 7'd3, 8'h5A, 16);                     // R1 R2
    check("R2 write reg3", 128'(cfg_o), 128'(flat()));
    xfer(1'b1, 7'd3, 8'hC3, 16);
    check("R1 R2 msb-first write", 128'(cfg_o[31:24]), 128'hC3);
    for (int i = 0; i < NREG; i++) xfer(1'b1, 7'(i), 8'(i * 37 + 5), 16);
    check("R2 all registers", 128'(cfg_o), 128'(flat()));
    xfer(1'b0, 7'd9, 8'h00, 16);

    xfer(1'b1, 7'd5, 8'h99, 10);                     // R5 aborted
    check("R5 abort at 10", 128'(cfg_o), 128'(flat()));
    xfer(1'b1, 7'd5, 8'h99, 15);
    check("R5 abort at 15", 128'(cfg_o), 128'(flat()));
    xfer(1'b1, 7'd5, 8'h3C, 16);
    check("R5 frame after abort", 128'(cfg_o[47:40]), 128'h3C);

    xfer(1'b1, 7'h20, 8'hEE, 16);                    // R7
    xfer(1'b0, 7'h7E, 8'h00, 16);
    check("R7 out of range", 128'(cfg_o), 128'(flat()));

    xfer(1'b1, 7'h7F, 8'h11, 16);                    // R6
    xfer(1'b1, 7'h7F, 8'hA2, 16);
    xfer(1'b1, 7'h7F, 8'hEE, 16);
    xfer(1'b0, 7'h7F, 8'h77, 16);
    check("R6 bank untouched", 128'(cfg_o), 128'(flat()));
    check("R6 all strobes seen", 128'(exp_mtx.size()), 128'h0);

    xfer(1'b1, 7'd15, 8'h00, 16);                    // R9
    pp_pulse = 1'b1; repeat (2) @(negedge clk);
    check("R9 bias follows pulse", 128'(pp_bias_sw), 128'h1);
    xfer(1'b1, 7'd15, 8'h01, 16);
    check("R9 bias blocked", 128'(pp_bias_sw), 128'h0);
    pp_pulse = 1'b0; repeat (2) @(negedge clk);
    check("R9 bias low", 128'(pp_bias_sw), 128'h0);
    xfer(1'b1, 7'd15, 8'hFE, 16);
    pp_pulse = 1'b1; repeat (2) @(negedge clk);
    check("R9 bias re-enabled", 128'(pp_bias_sw), 128'h1);

    rst_n = 1'b0; repeat (3) @(negedge clk);         // R8
    rst_n = 1'b1; load_defaults(); repeat (2) @(negedge clk);
    check("R8 reset restores defaults", 128'(cfg_o), 128'(DEF));
    xfer(1'b1, 7'd2, 8'h00, 16);
    check("R8 R3 queue drained", 128'(exp_miso.size()), 128'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule